// File: doc/BRIEF.md
# Synthesiser Phase Comparator and Lock Control

This block is the digital heart of a frequency synthesiser loop. A reference counter divides a stream of reference ticks by a ratio picked by a mode number and so produces the comparison pulse. A second counter divides the prescaled oscillator ticks by a programmable divider word and so produces the feedback pulse. A three-state phase/frequency detector turns the two pulse trains into charge-pump raise and lower commands.

A lock monitor measures how many clock cycles the detector holds a command in each comparison period. It declares lock after a run of quiet periods, and it drops lock on the first noisy one. Lock selects the low pump current and releases the open-drain lock flag.

A three-bit test code can take over several outputs. It can force the pump direction and current, force the lock flag, or send the comparison and halved feedback waveforms to two port pins. A pump-disable input silences both pump commands, whatever else is active.

Top module: `pll_cmp_lock`

## Requirements
- R1: The reference ratio is set by `mode`: 0 gives 640, 1 gives 2048, 2 gives 1024, 3 gives 1280, and 4 gives 512. Values 5 to 7 also give 512. One comparison period is that many `ref_tick` cycles. The comparison square wave is high for the first half of each period.
- R2: The feedback pulse occurs once every `div_word` `fb_tick` cycles. A `div_word` of 0 or 1 behaves as 2. An internal feedback toggle changes state on every feedback pulse.
- R3: A comparison pulse sets the raise command and a feedback pulse sets the lower command. Each command stays set until the other one is also set. One clock after both are set, both clear.
- R4: Lock is declared at the end of the 8th consecutive comparison period in which fewer than 4 cycles had a pump command active. Lock is dropped at the end of the first period with 4 or more such cycles.
- R5: With no test override active, `cur_hi` is 1 while out of lock and 0 while locked.
- R6: With no test override active, `lock_pull_low` is 1 while out of lock and 0 (released) while locked.
- R7: `cp_dis` = 1 forces `pump_up` and `pump_dn` to 0. This has priority over every other source, including test overrides.
- R8: `test_code` bit 2 is P1, bit 1 is P2 and bit 0 is P3. With `test_en` = 1, the codes act as follows: 000 gives lower only with `cur_hi`=1; 001 gives raise only with `cur_hi`=1; 100 gives lower only with `cur_hi`=0; 101 gives raise only with `cur_hi`=0.
- R9: With `test_en` = 1 and P2,P3 = 10 (P1 don't care), `route_en` is 1, `route_p2` carries the comparison square wave, `route_p3` carries the feedback toggle, and `lock_pull_low` is forced to 1. The pump commands and `cur_hi` behave normally.
- R10: With `test_en` = 1 and P2,P3 = 11 (P1 don't care), `lock_pull_low` is forced to 0 and `route_en` is 0. The pump commands and `cur_hi` behave normally.
- R11: With `test_en` = 0 the test code has no effect. `route_en`, `route_p2` and `route_p3` are 0 whenever routing is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference oscillator tick |
| fb_tick | input | 1 | One-cycle prescaled oscillator tick |
| mode | input | 3 | Reference ratio selector |
| div_word | input | 15 | Feedback divide ratio |
| cp_dis | input | 1 | Pump disable, both commands off |
| test_en | input | 1 | Enables the test code |
| test_code | input | 3 | {P1,P2,P3} test selection |
| pump_up | output | 1 | Raise-frequency pump command |
| pump_dn | output | 1 | Lower-frequency pump command |
| cur_hi | output | 1 | 1 selects the high pump current |
| lock_pull_low | output | 1 | Open-drain lock flag pull-down enable (1 = out of lock) |
| route_en | output | 1 | Port pins P2/P3 taken over by routing |
| route_p2 | output | 1 | Comparison square wave for P2 |
| route_p3 | output | 1 | Halved feedback waveform for P3 |

## Verification
The embedded properties assume that `ref_tick` and `fb_tick` are single-cycle enables. They also assume that a comparison ratio of at least 512 keeps comparison pulses far apart, so pulse-shape checks hold regardless of how dense the ticks are. The stimulus drives both tick streams either every cycle or held low. It changes `mode` and `div_word` only at a clock's falling edge, then waits long enough for both counters to wrap before it measures any period. Lock scenarios start the feedback stream a chosen number of cycles after the reference stream, so the phase error per period is known exactly.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int REF_MAX_RATIO = 2048;
    localparam int REF_CNT_W     = $clog2(REF_MAX_RATIO);
    localparam int REF_RATIO_W   = REF_CNT_W + 1;

    typedef logic [REF_RATIO_W-1:0] ref_ratio_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    typedef struct packed {
        logic pump_force;
        logic pump_up;
        logic cur_force;
        logic cur_hi;
        logic lock_force;
        logic lock_in;
        logic route;
    } test_ctl_t;

    // Mode number to reference divide ratio
    function automatic ref_ratio_t ref_ratio(input logic [2:0] mode);
        case (mode)
            3'd0:    return ref_ratio_t'(640);
            3'd1:    return ref_ratio_t'(2048);
            3'd2:    return ref_ratio_t'(1024);
            3'd3:    return ref_ratio_t'(1280);
            default: return ref_ratio_t'(512);
        endcase
    endfunction

    // code[2]=P1, code[1]=P2, code[0]=P3
    function automatic test_ctl_t decode_test(input logic en, input logic [2:0] code);
        test_ctl_t t;
        t = '0;
        if (en) begin
            if (!code[1]) begin
                t.pump_force = 1'b1;
                t.pump_up    = code[0];
                t.cur_force  = 1'b1;
                t.cur_hi     = !code[2];
            end else begin
                t.lock_force = 1'b1;
                t.lock_in    = code[0];
                t.route      = !code[0];
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/pcl_ref_div.sv
module pcl_ref_div
    import pcl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic [2:0] mode,
    output logic       comp_pulse,
    output logic       comp_level
);
    logic [REF_CNT_W-1:0] cnt;
    ref_ratio_t           ratio;

    assign ratio      = ref_ratio(mode);
    assign comp_level = ({1'b0, cnt} < (ratio >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            comp_pulse <= 1'b0;
        end else begin
            comp_pulse <= 1'b0;
            if (ref_tick) begin
                if ({1'b0, cnt} >= ratio - 1'b1) begin
                    cnt        <= '0;
                    comp_pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: ratios of at least 512 never give back-to-back comparison pulses
    p_comp_single_r1: assert property (@(posedge clk) disable iff (rst)
        comp_pulse |=> !comp_pulse);

endmodule

// File: rtl/pcl_fb_div.sv
module pcl_fb_div #(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fb_tick,
    input  logic [DIV_W-1:0] div_word,
    output logic             fpd_pulse,
    output logic             fb_half
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] n_eff;

    assign n_eff = (div_word < DIV_W'(2)) ? DIV_W'(2) : div_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            fpd_pulse <= 1'b0;
            fb_half   <= 1'b0;
        end else begin
            fpd_pulse <= 1'b0;
            if (fb_tick) begin
                if (cnt >= n_eff - 1'b1) begin
                    cnt       <= '0;
                    fpd_pulse <= 1'b1;
                    fb_half   <= !fb_half;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: the ratio floor of 2 keeps feedback pulses isolated
    p_fpd_single_r2: assert property (@(posedge clk) disable iff (rst)
        fpd_pulse |=> !fpd_pulse);

    // R2: the toggle moves only together with a feedback pulse
    p_half_with_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(fb_half) |-> fpd_pulse);

endmodule

// File: rtl/pcl_pfd.sv
module pcl_pfd
    import pcl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  comp_pulse,
    input  logic  fpd_pulse,
    output pump_t cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (cmd.up && cmd.dn) begin
            cmd.up <= comp_pulse;
            cmd.dn <= fpd_pulse;
        end else begin
            cmd.up <= cmd.up | comp_pulse;
            cmd.dn <= cmd.dn | fpd_pulse;
        end
    end

    // R3: both commands never survive past one cycle together
    p_clear_both_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.up && cmd.dn && !(comp_pulse && fpd_pulse)) |=> !(cmd.up && cmd.dn));

    // R3: a lone raise command holds until feedback arrives
    p_up_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.up && !cmd.dn && !fpd_pulse) |=> cmd.up);

endmodule

// File: rtl/pcl_lock_det.sv
module pcl_lock_det #(
    parameter int ERR_LIMIT    = 4,
    parameter int LOCK_PERIODS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic comp_pulse,
    input  logic err_active,
    output logic locked
);
    localparam int ERR_W  = $clog2(ERR_LIMIT + 1);
    localparam int GOOD_W = $clog2(LOCK_PERIODS + 1);
    localparam logic [ERR_W-1:0]  ERR_MAX  = ERR_W'(ERR_LIMIT);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_PERIODS);

    logic [ERR_W-1:0]  err_acc;
    logic [GOOD_W-1:0] good;
    logic              bad_period;
    logic [GOOD_W-1:0] good_nxt;

    assign bad_period = (err_acc >= ERR_MAX);
    assign good_nxt   = (good >= GOOD_MAX) ? GOOD_MAX : good + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_acc <= '0;
            good    <= '0;
            locked  <= 1'b0;
        end else if (comp_pulse) begin
            err_acc <= '0;
            if (bad_period) begin
                good   <= '0;
                locked <= 1'b0;
            end else begin
                good   <= good_nxt;
                locked <= (good_nxt == GOOD_MAX);
            end
        end else if (err_active && err_acc < ERR_MAX) begin
            err_acc <= err_acc + 1'b1;
        end
    end

    // R4: a noisy period ends lock at once
    p_drop_on_bad_r4: assert property (@(posedge clk) disable iff (rst)
        (comp_pulse && bad_period) |=> !locked);

    // R4: lock is only ever gained at a comparison boundary
    p_lock_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(comp_pulse));

endmodule

// File: rtl/pll_cmp_lock.sv
module pll_cmp_lock
    import pcl_pkg::*;
#(
    parameter int DIV_W        = 15,
    parameter int ERR_LIMIT    = 4,
    parameter int LOCK_PERIODS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             fb_tick,
    input  logic [2:0]       mode,
    input  logic [DIV_W-1:0] div_word,
    input  logic             cp_dis,
    input  logic             test_en,
    input  logic [2:0]       test_code,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             cur_hi,
    output logic             lock_pull_low,
    output logic             route_en,
    output logic             route_p2,
    output logic             route_p3
);
    logic      comp_pulse;
    logic      comp_level;
    logic      fpd_pulse;
    logic      fb_half;
    logic      locked;
    pump_t     pfd_cmd;
    pump_t     out_cmd;
    test_ctl_t tc;

    pcl_ref_div u_ref (
        .clk        (clk),
        .rst        (rst),
        .ref_tick   (ref_tick),
        .mode       (mode),
        .comp_pulse (comp_pulse),
        .comp_level (comp_level)
    );

    pcl_fb_div #(.DIV_W(DIV_W)) u_fb (
        .clk       (clk),
        .rst       (rst),
        .fb_tick   (fb_tick),
        .div_word  (div_word),
        .fpd_pulse (fpd_pulse),
        .fb_half   (fb_half)
    );

    pcl_pfd u_pfd (
        .clk        (clk),
        .rst        (rst),
        .comp_pulse (comp_pulse),
        .fpd_pulse  (fpd_pulse),
        .cmd        (pfd_cmd)
    );

    pcl_lock_det #(.ERR_LIMIT(ERR_LIMIT), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .comp_pulse (comp_pulse),
        .err_active (pfd_cmd.up | pfd_cmd.dn),
        .locked     (locked)
    );

    assign tc = decode_test(test_en, test_code);

    always_comb begin
        out_cmd = pfd_cmd;
        if (tc.pump_force) begin
            out_cmd.up = tc.pump_up;
            out_cmd.dn = !tc.pump_up;
        end
        if (cp_dis) out_cmd = '0;
    end

    assign pump_up       = out_cmd.up;
    assign pump_dn       = out_cmd.dn;
    assign cur_hi        = tc.cur_force  ? tc.cur_hi   : !locked;
    assign lock_pull_low = tc.lock_force ? !tc.lock_in : !locked;
    assign route_en      = tc.route;
    assign route_p2      = tc.route & comp_level;
    assign route_p3      = tc.route & fb_half;

    // R5: current drops only after the lock monitor has reported lock
    p_cur_low_locked_r5: assert property (@(posedge clk) disable iff (rst)
        (!test_en && $fell(cur_hi)) |-> $rose(locked));

endmodule

// File: tb/sim_pll_cmp_lock.sv
module sim_pll_cmp_lock;
    logic        clk = 1'b0;
    logic        rst;
    logic        ref_tick, fb_tick;
    logic [2:0]  mode;
    logic [14:0] div_word;
    logic        cp_dis, test_en;
    logic [2:0]  test_code;
    logic        pump_up, pump_dn, cur_hi, lock_pull_low, route_en, route_p2, route_p3;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = !clk;

    pll_cmp_lock u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .mode(mode), .div_word(div_word), .cp_dis(cp_dis), .test_en(test_en),
        .test_code(test_code), .pump_up(pump_up), .pump_dn(pump_dn),
        .cur_hi(cur_hi), .lock_pull_low(lock_pull_low), .route_en(route_en),
        .route_p2(route_p2), .route_p3(route_p3)
    );

    function automatic int exp_ratio(input int m);
        case (m)
            0: return 640;
            1: return 2048;
            2: return 1024;
            3: return 1280;
            default: return 512;
        endcase
    endfunction

    function automatic int exp_fb_period(input int n);
        return 2 * ((n < 2) ? 2 : n);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int m, input int dw);
        @(negedge clk);
        rst = 1'b1; ref_tick = 1'b0; fb_tick = 1'b0;
        mode = 3'(m); div_word = 15'(dw);
        cp_dis = 1'b0; test_en = 1'b0; test_code = 3'b000;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    // rising edge to rising edge distance of route_p2 (sel 0) or route_p3 (sel 1)
    task automatic measure(input int sel, output int per);
        logic prev, cur;
        int   cnt;
        per  = -1;
        prev = sel ? route_p3 : route_p2;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            cur = sel ? route_p3 : route_p2;
            if (!prev && cur) break;
            prev = cur;
        end
        prev = 1'b1;
        cnt  = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            cnt++;
            cur = sel ? route_p3 : route_p2;
            if (!prev && cur) begin
                per = cnt;
                break;
            end
            prev = cur;
        end
    endtask

    // start reference ticks, then feedback ticks k cycles later
    task automatic start_streams(input int k);
        ref_tick = 1'b1;
        if (k > 0) wait_cyc(k);
        fb_tick = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int per;
        int k;
        void'($urandom(32'd20240611));

        // reset state (R5, R6, R11)
        do_reset(4, 1000);
        @(negedge clk);
        chk("R3 reset up", pump_up, 0);
        chk("R3 reset dn", pump_dn, 0);
        chk("R5 reset cur_hi", cur_hi, 1);
        chk("R6 reset lock flag", lock_pull_low, 1);
        chk("R11 reset route_en", route_en, 0);

        // R3: reference leads, no feedback at all
        ref_tick = 1'b1;
        wait_cyc(600);
        chk("R3 up after comparison", pump_up, 1);
        chk("R3 dn idle", pump_dn, 0);
        cp_dis = 1'b1;
        @(negedge clk);
        chk("R7 disable up", pump_up, 0);
        chk("R7 disable dn", pump_dn, 0);
        cp_dis = 1'b0;
        wait_cyc(400);
        chk("R3 up held", pump_up, 1);

        // R3: feedback leads
        do_reset(1, 100);
        start_streams(0);
        wait_cyc(300);
        chk("R3 dn after feedback", pump_dn, 1);
        chk("R3 up idle", pump_up, 0);

        // R4/R5/R6: small phase offset locks
        k = $urandom_range(2, 0);
        do_reset(4, 512);
        start_streams(k);
        wait_cyc(600);
        chk("R3 both cleared", pump_up | pump_dn, 0);
        wait_cyc(2800);
        chk("R4 not yet locked", lock_pull_low, 1);
        chk("R5 high current unlocked", cur_hi, 1);
        wait_cyc(900);
        chk("R6 flag released when locked", lock_pull_low, 0);
        chk("R5 low current locked", cur_hi, 0);

        // R11: code ignored without test enable
        test_code = 3'b000;
        @(negedge clk);
        chk("R11 cur unaffected", cur_hi, 0);
        chk("R11 lock unaffected", lock_pull_low, 0);
        chk("R11 route off", route_en, 0);

        // R8 forced pump table
        test_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            logic [2:0] code;
            code = (c < 2) ? 3'(c) : 3'(c + 2);
            test_code = code;
            @(negedge clk);
            chk($sformatf("R8 code %0d up", code), pump_up, code[0]);
            chk($sformatf("R8 code %0d dn", code), pump_dn, !code[0]);
            chk($sformatf("R8 code %0d cur", code), cur_hi, !code[2]);
            chk($sformatf("R8 code %0d lock", code), lock_pull_low, 0);
        end
        test_code = 3'b001;
        cp_dis = 1'b1;
        @(negedge clk);
        chk("R7 over test up", pump_up, 0);
        chk("R7 over test dn", pump_dn, 0);
        cp_dis = 1'b0;

        // R9 routing while locked, both P1 values
        for (int p1 = 0; p1 < 2; p1++) begin
            test_code = {1'(p1), 2'b10};
            @(negedge clk);
            chk("R9 lock forced out", lock_pull_low, 1);
            chk("R9 cur normal", cur_hi, 0);
            chk("R9 route_en", route_en, 1);
        end
        test_en = 1'b0;

        // R4: frequency error drops lock
        div_word = 15'd400;
        wait_cyc(1600);
        chk("R4 lock dropped", lock_pull_low, 1);
        chk("R5 current back high", cur_hi, 1);

        // R10 forced in-lock, both P1 values
        test_en = 1'b1;
        for (int p1 = 0; p1 < 2; p1++) begin
            test_code = {1'(p1), 2'b11};
            @(negedge clk);
            chk("R10 lock forced in", lock_pull_low, 0);
            chk("R10 route off", route_en, 0);
            chk("R10 cur normal", cur_hi, 1);
        end
        test_en = 1'b0;

        // R4: offset of 5 gives 6 error cycles per period, never locks
        do_reset(4, 512);
        start_streams(5);
        wait_cyc(6000);
        chk("R4 large offset no lock", lock_pull_low, 1);

        // R1: comparison period per mode through port routing
        do_reset(0, 30000);
        ref_tick = 1'b1;
        test_en = 1'b1;
        test_code = 3'b010;
        for (int i = 0; i < 6; i++) begin
            int m;
            m = (i == 5) ? 6 : ((i + 3) % 5);
            mode = 3'(m);
            wait_cyc(2100);
            measure(0, per);
            chk($sformatf("R1 mode %0d period", m), per, exp_ratio(m));
        end

        // R2: feedback toggle period, random words plus floor cases
        fb_tick = 1'b1;
        for (int i = 0; i < 7; i++) begin
            int n;
            n = (i == 5) ? 0 : (i == 6) ? 1 : int'($urandom_range(700, 2));
            div_word = 15'(n);
            wait_cyc(1500);
            measure(1, per);
            chk($sformatf("R2 word %0d period", n), per, exp_fb_period(n));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule